// File: doc/BRIEF.md
# Sixteen-Bit ALU With Status and Control Flag Word

This block performs one arithmetic or logical operation per enabled clock on two 16-bit operands, in either byte or word size. It registers the result and updates a 16-bit flag word. That word holds six status flags, which describe the last result, and three control flags. The control flags change only through dedicated command inputs. Carry-in for the add-with-carry and subtract-with-borrow operations comes from the carry flag that the block itself holds, so multi-word arithmetic is a sequence of enabled cycles.

The status flags are:
- carry (unsigned carry out or borrow)
- parity (even count of ones in the low byte)
- auxiliary carry (across bits 3 and 4)
- zero
- sign
- signed overflow

The control flags are trap, interrupt enable and direction. Separate strobes set and clear direction and interrupt enable. Trap can only be set by its strobe. Reset clears all three.

Top module: `alu_flags16`

## Requirements
- R1: After reset, `result` is 0 and every bit of `flags` is 0.
- R2: The op encodings are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 increment, 5 AND, 6 OR and 7 XOR. Carry-in for op 1 and borrow-in for op 3 is the carry flag (flags bit 0) held before the operation. In word mode, carry is the carry out of bit 15 for add and the borrow for subtract.
- R3: When `en` is high at a rising edge, `result` and the status flags take the new values, and these are visible after that edge.
- R4: Overflow (flags bit 11) is 1 when the signed result does not fit in the operand size.
- R5: Sign (flags bit 7) is the top bit of the result at the selected size. Zero (flags bit 6) is 1 when the result at that size is all zeros.
- R6: Auxiliary carry (flags bit 4) is 1 on a carry out of bit 3 for add, or a borrow into bit 3 for subtract.
- R7: Parity (flags bit 2) is 1 when the low 8 bits of the result hold an even number of ones.
- R8: AND, OR and XOR clear carry, overflow and auxiliary carry.
- R9: Increment updates every status flag except carry, which keeps its old value.
- R10: When `byte_mode` is 1, only the low 8 bits of the operands are used. `result[15:8]` is 0, and carry, overflow and sign are taken at bit 7.
- R11: When `en` is low, `result` and the status flags hold their values, whatever the operand inputs do.
- R12: `dir_set` and `dir_clr` set and clear direction (bit 10). `int_set` and `int_clr` set and clear interrupt enable (bit 9). Set wins if both strobes of a pair are high. `trap_set` sets trap (bit 8). These strobes work whether `en` is high or low.
- R13: Control bits 8 to 10 never change because of an operation. Bits 1, 3, 5 and 12 to 15 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Perform the operation this cycle |
| op | input | 3 | Operation code |
| byte_mode | input | 1 | 1 selects byte size, 0 selects word size |
| a | input | 16 | First operand (minuend for subtract) |
| b | input | 16 | Second operand (ignored by increment) |
| dir_set | input | 1 | Set the direction flag |
| dir_clr | input | 1 | Clear the direction flag |
| int_set | input | 1 | Set the interrupt-enable flag |
| int_clr | input | 1 | Clear the interrupt-enable flag |
| trap_set | input | 1 | Set the trap flag |
| result | output | 16 | Registered result |
| flags | output | 16 | Flag word |

## Verification
The hardest cases to reach are the ones that depend on a carry flag left by an earlier operation. These are add-with-carry and subtract-with-borrow with a carry-in of 1, and an increment that must keep a carry of 1 rather than clear it. The only way to set up that state is through the ports, so each scenario chains operations. A first operation is chosen to produce a known carry, then the dependent operation runs on the next enabled cycle. The bench's own model follows the carry across the sequence.

// File: rtl/alu_flags16.sv
module alu_flags16 #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [2:0]   op,
  input  logic         byte_mode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         dir_set,
  input  logic         dir_clr,
  input  logic         int_set,
  input  logic         int_clr,
  input  logic         trap_set,
  output logic [W-1:0] result,
  output logic [15:0]  flags
);
  localparam int FC = 0, FP = 2, FA = 4, FZ = 6, FS = 7, FT = 8, FI = 9, FD = 10, FO = 11;
  localparam logic [2:0] OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3, OP_INC = 3'd4,
                         OP_AND = 3'd5, OP_OR = 3'd6;

  logic         is_sub, is_logic, cin;
  logic [W-1:0] bop, lres, res;
  logic [W:0]   wfull;
  logic [BW:0]  bfull;
  logic         as, bs, rs, cy, ov, ac, zr, pr;

  assign is_sub   = (op == OP_SUB) || (op == OP_SBB);
  assign is_logic = op[2] & (op[1] | op[0]);
  assign cin      = ((op == OP_ADC) || (op == OP_SBB)) & flags[FC];
  assign bop      = (op == OP_INC) ? W'(1) : b;

  assign wfull = is_sub ? ({1'b0, a} - {1'b0, bop} - (W+1)'(cin))
                        : ({1'b0, a} + {1'b0, bop} + (W+1)'(cin));
  assign bfull = is_sub ? ({1'b0, a[BW-1:0]} - {1'b0, bop[BW-1:0]} - (BW+1)'(cin))
                        : ({1'b0, a[BW-1:0]} + {1'b0, bop[BW-1:0]} + (BW+1)'(cin));

  always_comb begin
    case (op)
      OP_AND:  lres = a & b;
      OP_OR:   lres = a | b;
      default: lres = a ^ b;
    endcase
    if (is_logic)
      res = byte_mode ? {{(W-BW){1'b0}}, lres[BW-1:0]} : lres;
    else
      res = byte_mode ? {{(W-BW){1'b0}}, bfull[BW-1:0]} : wfull[W-1:0];
  end

  assign as = byte_mode ? a[BW-1]   : a[W-1];
  assign bs = byte_mode ? bop[BW-1] : bop[W-1];
  assign rs = byte_mode ? res[BW-1] : res[W-1];
  assign cy = byte_mode ? bfull[BW] : wfull[W];
  assign ov = is_sub ? (as != bs) && (rs != as) : (as == bs) && (rs != as);
  assign ac = a[4] ^ bop[4] ^ res[4];
  assign zr = byte_mode ? (res[BW-1:0] == '0) : (res == '0);
  assign pr = ~^res[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      flags  <= '0;
    end else begin
      if (en) begin
        result    <= res;
        flags[FC] <= is_logic ? 1'b0 : ((op == OP_INC) ? flags[FC] : cy);
        flags[FO] <= is_logic ? 1'b0 : ov;
        flags[FA] <= is_logic ? 1'b0 : ac;
        flags[FS] <= rs;
        flags[FZ] <= zr;
        flags[FP] <= pr;
      end
      if (dir_set)      flags[FD] <= 1'b1;
      else if (dir_clr) flags[FD] <= 1'b0;
      if (int_set)      flags[FI] <= 1'b1;
      else if (int_clr) flags[FI] <= 1'b0;
      if (trap_set)     flags[FT] <= 1'b1;
    end
  end

  // R8
  logic_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && is_logic |=> !flags[FC] && !flags[FO] && !flags[FA]);

  // R9
  inc_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == OP_INC |=> flags[FC] == $past(flags[FC]));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(result) && $stable({flags[FO], flags[7:0]}));

  // R13
  ctl_only_by_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dir_set || dir_clr || int_set || int_clr || trap_set) |=> $stable(flags[FD:FT]));

  // R12
  trap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_set |=> flags[FT]);

  // R5
  zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !byte_mode |=> flags[FZ] == (result == '0));

  // R10
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && byte_mode |=> result[W-1:BW] == '0);
endmodule

// File: tb/alu_flags16_tb_top.sv
`timescale 1ns/1ps
module alu_flags16_tb_top;
  logic clk = 0, rst_n = 0, en = 0, byte_mode = 0;
  logic [2:0] op = 0;
  logic [15:0] a = 0, b = 0;
  logic dir_set = 0, dir_clr = 0, int_set = 0, int_clr = 0, trap_set = 0;
  logic [15:0] result, flags;
  int checks = 0, errors = 0;
  logic [15:0] exp_ctl = 0;
  logic [15:0] exp_res = 0, exp_st = 0;

  always #10 clk = ~clk;

  alu_flags16 dut_i (.clk(clk), .rst_n(rst_n), .en(en), .op(op), .byte_mode(byte_mode),
    .a(a), .b(b), .dir_set(dir_set), .dir_clr(dir_clr), .int_set(int_set),
    .int_clr(int_clr), .trap_set(trap_set), .result(result), .flags(flags));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic void model(input logic [2:0] o, input bit bm, input logic [15:0] x,
                                input logic [15:0] y, input bit cf,
                                output logic [15:0] r, output logic [15:0] st);
    int w = bm ? 8 : 16;
    longint mask = (longint'(1) << w) - 1;
    longint half = longint'(1) << (w - 1);
    longint ua = longint'(x) & mask, ub = longint'(y) & mask, full = 0, rr, sa, sb, sr;
    bit c = 0, ov = 0, ax = 0, add, cin;
    int ones = 0;
    if (o == 3'd4) ub = 1;
    cin = (o == 3'd1 || o == 3'd3) ? cf : 1'b0;
    add = (o == 3'd0 || o == 3'd1 || o == 3'd4);
    sa = (ua >= half) ? ua - 2*half : ua;
    sb = (ub >= half) ? ub - 2*half : ub;
    if (o >= 3'd5) begin
      rr = (o == 3'd5) ? (ua & ub) : (o == 3'd6) ? (ua | ub) : (ua ^ ub);
    end else if (add) begin
      full = ua + ub + longint'(cin);
      c = full > mask;
      ax = ((ua & 15) + (ub & 15) + longint'(cin)) > 15;
      sr = sa + sb + longint'(cin);
      ov = (sr > half - 1) || (sr < -half);
      rr = full & mask;
    end else begin
      full = ua - ub - longint'(cin);
      c = full < 0;
      ax = (ua & 15) < ((ub & 15) + longint'(cin));
      sr = sa - sb - longint'(cin);
      ov = (sr > half - 1) || (sr < -half);
      rr = full & mask;
    end
    if (o == 3'd4) c = cf;
    for (int i = 0; i < 8; i++) ones += int'((rr >> i) & 1);
    r = 16'(rr);
    st = 0;
    st[0] = c; st[11] = ov; st[4] = ax;
    st[7] = ((rr >> (w - 1)) & 1) != 0;
    st[6] = (rr == 0);
    st[2] = (ones % 2 == 0);
  endfunction

  task automatic do_op(input string tag, input logic [2:0] o, input bit bm,
                       input logic [15:0] x, input logic [15:0] y);
    model(o, bm, x, y, exp_st[0], exp_res, exp_st);
    @(negedge clk);
    op = o; byte_mode = bm; a = x; b = y; en = 1;
    @(negedge clk);
    en = 0;
    chk({tag, " result"}, result, exp_res);
    chk({tag, " flags"}, flags, exp_st | exp_ctl);
  endtask

  task automatic t_reset;
    chk("R1 result", result, 16'h0);
    chk("R1 flags", flags, 16'h0);
  endtask

  task automatic t_add;
    do_op("R2 R3 add", 3'd0, 0, 16'h1234, 16'h4321);
    do_op("R2 add carry", 3'd0, 0, 16'hFFFF, 16'h0002);
    do_op("R2 adc cin", 3'd1, 0, 16'h0010, 16'h0020);
    do_op("R4 R5 add overflow", 3'd0, 0, 16'h7FFF, 16'h0001);
    do_op("R4 neg overflow", 3'd0, 0, 16'h8000, 16'h8000);
  endtask

  task automatic t_sub;
    do_op("R2 sub borrow", 3'd2, 0, 16'h0000, 16'h0001);
    do_op("R2 sbb bin", 3'd3, 0, 16'h0100, 16'h0000);
    do_op("R4 sub overflow", 3'd2, 0, 16'h8000, 16'h0001);
    do_op("R6 sub aux", 3'd2, 0, 16'h0010, 16'h0001);
    do_op("R5 sub zero", 3'd2, 0, 16'h5A5A, 16'h5A5A);
  endtask

  task automatic t_inc;
    do_op("R9 setup", 3'd0, 0, 16'hFFFF, 16'h0001);
    do_op("R9 inc keep carry", 3'd4, 0, 16'h000F, 16'hBEEF);
    do_op("R9 inc wrap", 3'd4, 0, 16'hFFFF, 16'h0000);
    do_op("R9 clr carry", 3'd2, 0, 16'h0005, 16'h0001);
    do_op("R9 inc ovf", 3'd4, 0, 16'h7FFF, 16'h0000);
  endtask

  task automatic t_logic;
    do_op("R8 setup", 3'd0, 0, 16'hFFFF, 16'h8001);
    do_op("R8 and", 3'd5, 0, 16'hF0F0, 16'h0FF0);
    do_op("R8 or", 3'd6, 0, 16'h0003, 16'h8000);
    do_op("R7 xor parity", 3'd7, 0, 16'hFFFF, 16'hFF01);
  endtask

  task automatic t_byte;
    do_op("R10 byte add", 3'd0, 1, 16'h12FF, 16'h3401);
    do_op("R10 byte ovf", 3'd0, 1, 16'hAA7F, 16'h5501);
    do_op("R10 byte sub", 3'd2, 1, 16'hFF00, 16'h0001);
    do_op("R10 byte xor", 3'd7, 1, 16'hFF0F, 16'h00F0);
  endtask

  task automatic t_hold;
    @(negedge clk);
    a = 16'hDEAD; b = 16'hBEEF; op = 3'd2; byte_mode = 0; en = 0;
    @(negedge clk);
    a = 16'h0001; op = 3'd7;
    @(negedge clk);
    chk("R11 result hold", result, exp_res);
    chk("R11 flags hold", flags, exp_st | exp_ctl);
  endtask

  task automatic t_ctl;
    @(negedge clk); dir_set = 1; exp_ctl[10] = 1;
    @(negedge clk); dir_set = 0;
    chk("R12 dir set", flags, exp_st | exp_ctl);
    dir_clr = 1; exp_ctl[10] = 0;
    @(negedge clk); dir_clr = 0;
    chk("R12 dir clr", flags, exp_st | exp_ctl);
    int_set = 1; int_clr = 1; exp_ctl[9] = 1;
    @(negedge clk); int_set = 0; int_clr = 0;
    chk("R12 int set wins", flags, exp_st | exp_ctl);
    trap_set = 1; dir_set = 1; exp_ctl[8] = 1; exp_ctl[10] = 1;
    @(negedge clk); trap_set = 0; dir_set = 0;
    chk("R12 trap set", flags, exp_st | exp_ctl);
    do_op("R13 op keeps ctl", 3'd0, 0, 16'hFFFF, 16'hFFFF);
    do_op("R13 logic keeps ctl", 3'd5, 0, 16'h0000, 16'hFFFF);
    int_clr = 1; exp_ctl[9] = 0;
    @(negedge clk); int_clr = 0;
    chk("R12 int clr", flags, exp_st | exp_ctl);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_inc();
    t_logic();
    t_byte();
    t_hold();
    t_ctl();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule